// File: doc/BRIEF.md
# Demand-Allocating Page Mapper with Stall

This block sits between an 8-bit processor with a 16-bit address bus and a wider physical memory. It splits the 64 KB logical space into sixteen 4 KB pages. Each page has one map entry holding a frame number and three attribute bits. The physical address is the frame number joined to the 12-bit in-page offset. Frame count and physical width follow from the `FW` parameter.

When the processor presents an address in a page that has no frame yet, the block pulls ready low in that same cycle, so the processor freezes with its bus held steady. The block then claims the lowest-numbered free frame from an occupancy bitmap and installs the mapping. After that it raises ready, and the stalled access completes against the new frame without any software involvement. This applies to opcode fetches, operand fetches and data accesses alike.

Pages can be tagged as program space. A write to such a page, or a non-fetch read from it when the page is not marked data-readable, raises a sticky violation flag and the interrupt instead of allocating. If the pool has no free frame, the block raises an out-of-memory flag and the interrupt, and still releases ready so the processor is never held forever. In that case a write is dropped and read data is forced to 0xFF. Software uses a small command port to read or write entries, free frames and clear the flags. Commands are taken only while no allocation is in progress.

Top module: `pm_demand_mapper`

## Requirements
- R1: For an access to a page whose entry is valid, ready stays high with no stall and `phys_addr` = {frame, cpu_addr[11:0]}; a write asserts `mem_we` while `cpu_phi2` is high.
- R2: After reset every entry is invalid except logical page 15, which is valid with frame `VEC_FRAME` and attributes clear; that frame is marked occupied; both flags and `irq` are low.
- R3: An access to a page with an invalid entry drives `cpu_rdy` low in the same clock cycle. It holds ready low for exactly two clock cycles and then raises it with the new mapping in place. This holds for fetches (`cpu_sync`=1) and for data accesses.
- R4: The allocator picks the lowest-numbered free frame, marks it occupied, and writes the entry valid with the program and data-readable bits clear.
- R5: A write to a program-tagged page leaves ready high and keeps `mem_we` low. It sets `stat_viol` and `irq` after the phase-2 high cycle.
- R6: A read from a program-tagged page with `cpu_sync`=0 and data-readable clear is a violation (sets `stat_viol`). With `cpu_sync`=1, or with data-readable set, it is not.
- R7: With no free frame, a miss sets `stat_oom` and `irq` and releases ready after the two-cycle stall. Until phase 2 next falls, `mem_we` stays low and `mem_rd_ff` equals `cpu_rw`. The entry stays invalid.
- R8: Command READ (`sw_op`=0) returns the entry of `sw_page` on `sw_rdata` one clock later, laid out as bits [FW-1:0] frame, [FW] valid, [FW+1] program tag, [FW+2] data-readable.
- R9: Command WRITE (`sw_op`=1) loads the entry of `sw_page` from `sw_frame`, `sw_valid`, `sw_prog` and `sw_dread`. When `sw_valid` is set, that frame is marked occupied.
- R10: Command FREE (`sw_op`=2) marks `sw_frame` free and invalidates every entry that points at it, so a later miss can reclaim it.
- R11: Command CLEAR (`sw_op`=3) clears `stat_oom` and `stat_viol`, which drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the processor bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical address from the processor |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_sync | input | 1 | High during an opcode fetch |
| cpu_phi2 | input | 1 | Processor clock phase 2 |
| cpu_rdy | output | 1 | Ready to the processor; low stalls it |
| phys_addr | output | FW+12 | Translated physical address |
| mem_we | output | 1 | Write strobe to physical memory |
| mem_rd_ff | output | 1 | Force read data to 0xFF |
| irq | output | 1 | Interrupt: any fault flag set |
| stat_oom | output | 1 | Sticky out-of-memory flag |
| stat_viol | output | 1 | Sticky access-violation flag |
| sw_en | input | 1 | Command strobe, one cycle |
| sw_op | input | 2 | 0 READ, 1 WRITE, 2 FREE, 3 CLEAR |
| sw_page | input | 4 | Logical page for READ/WRITE |
| sw_frame | input | FW | Frame for WRITE/FREE |
| sw_valid | input | 1 | Valid bit for WRITE |
| sw_prog | input | 1 | Program tag for WRITE |
| sw_dread | input | 1 | Data-readable bit for WRITE |
| sw_rdata | output | FW+3 | Entry returned by READ |

## Verification
The bench builds the block with `FW`=3 and `VEC_FRAME`=7, which gives an eight-frame pool with the vector page in the top frame. With so few frames, a short run of misses fills the pool, so the out-of-memory release path is reachable after a handful of accesses. The small pool also lets frees and lowest-free reuse be followed frame by frame. The default of 256 frames keeps the same logic and only widens the bitmap search.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int LAW    = 16;              // logical address width
    localparam int OFS_W  = 12;              // in-page offset width
    localparam int LPG_W  = LAW - OFS_W;     // logical page index width
    localparam int NPAGES = 1 << LPG_W;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FREE  = 2'd2,
        OP_CLEAR = 2'd3
    } pm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIND = 2'd1,
        ST_OOM  = 2'd2
    } pm_state_e;

    typedef struct packed {
        logic dread;   // data reads allowed on a program page
        logic prog;    // program-space tag
        logic valid;   // frame assigned
    } pm_attr_t;

    function automatic logic is_violation(pm_attr_t a, logic rw, logic sync);
        return a.valid && a.prog && (!rw || (!sync && !a.dread));
    endfunction
endpackage

// File: rtl/pm_map_table.sv
module pm_map_table
    import pm_pkg::*;
#(
    parameter int FW        = 8,
    parameter int VEC_FRAME = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LPG_W-1:0] lk_page,
    output pm_attr_t         lk_attr,
    output logic [FW-1:0]    lk_frame,
    input  logic [LPG_W-1:0] rd_page,
    output pm_attr_t         rd_attr,
    output logic [FW-1:0]    rd_frame,
    input  logic             wr_en,
    input  logic [LPG_W-1:0] wr_page,
    input  pm_attr_t         wr_attr,
    input  logic [FW-1:0]    wr_frame,
    input  logic             inv_en,
    input  logic [FW-1:0]    inv_frame
);
    pm_attr_t      ent_attr  [NPAGES];
    logic [FW-1:0] ent_frame [NPAGES];

    for (genvar p = 0; p < NPAGES; p++) begin : g_ent
        localparam bit IS_VEC = (p == NPAGES - 1);
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_attr[p]  <= '{dread: 1'b0, prog: 1'b0, valid: IS_VEC};
                ent_frame[p] <= IS_VEC ? FW'(VEC_FRAME) : '0;
            end else if (wr_en && wr_page == LPG_W'(p)) begin
                ent_attr[p]  <= wr_attr;
                ent_frame[p] <= wr_frame;
            end else if (inv_en && ent_frame[p] == inv_frame) begin
                ent_attr[p].valid <= 1'b0;
            end
        end

        // R10: an entry pointing at a freed frame loses its mapping
        a_r10_free_invalidates: assert property (@(posedge clk) disable iff (rst)
            (inv_en && ent_frame[p] == inv_frame && !(wr_en && wr_page == LPG_W'(p)))
            |=> !ent_attr[p].valid);
    end

    assign lk_attr  = ent_attr[lk_page];
    assign lk_frame = ent_frame[lk_page];
    assign rd_attr  = ent_attr[rd_page];
    assign rd_frame = ent_frame[rd_page];
endmodule

// File: rtl/pm_frame_pool.sv
module pm_frame_pool #(
    parameter int FW        = 8,
    parameter int VEC_FRAME = 255
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [FW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [FW-1:0] clr_idx,
    output logic          any_free,
    output logic [FW-1:0] low_free
);
    localparam int NF = 1 << FW;

    logic [NF-1:0] occ;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ            <= '0;
            occ[VEC_FRAME] <= 1'b1;
        end else begin
            if (clr_en) occ[clr_idx] <= 1'b0;
            if (set_en) occ[set_idx] <= 1'b1;
        end
    end

    always_comb begin
        low_free = '0;
        for (int i = NF - 1; i >= 0; i--) begin
            if (!occ[i]) low_free = FW'(i);
        end
    end

    assign any_free = ~&occ;

    // R4: the offered frame is really free
    a_r4_offer_is_free: assert property (@(posedge clk) disable iff (rst)
        any_free |-> !occ[low_free]);

    // R10: a freed frame is back in the pool next cycle
    a_r10_free_returns: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !occ[$past(clr_idx)]);
endmodule

// File: rtl/pm_demand_mapper.sv
module pm_demand_mapper
    import pm_pkg::*;
#(
    parameter int FW        = 8,
    parameter int VEC_FRAME = 255,
    localparam int PAW      = FW + OFS_W,
    localparam int EW       = FW + 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LAW-1:0]  cpu_addr,
    input  logic            cpu_rw,
    input  logic            cpu_sync,
    input  logic            cpu_phi2,
    output logic            cpu_rdy,
    output logic [PAW-1:0]  phys_addr,
    output logic            mem_we,
    output logic            mem_rd_ff,
    output logic            irq,
    output logic            stat_oom,
    output logic            stat_viol,
    input  logic            sw_en,
    input  logic [1:0]      sw_op,
    input  logic [LPG_W-1:0] sw_page,
    input  logic [FW-1:0]   sw_frame,
    input  logic            sw_valid,
    input  logic            sw_prog,
    input  logic            sw_dread,
    output logic [EW-1:0]   sw_rdata
);
    pm_state_e        state;
    logic [LPG_W-1:0] miss_page;
    logic             phi2_q;

    pm_attr_t      lk_attr, rd_attr, wr_attr;
    logic [FW-1:0] lk_frame, rd_frame, wr_frame, low_free;
    logic          any_free;

    logic          miss, viol, viol_hit, alloc_go, sw_ok, phi2_fall;
    logic          sw_wr, sw_free, sw_rd, sw_clr;
    logic          tbl_we, pool_set;
    logic [LPG_W-1:0] wr_page;
    pm_op_e        op;

    assign op        = pm_op_e'(sw_op);
    assign miss      = !lk_attr.valid;
    assign viol      = is_violation(lk_attr, cpu_rw, cpu_sync);
    assign phi2_fall = phi2_q && !cpu_phi2;
    assign alloc_go  = (state == ST_FIND) && any_free;
    assign sw_ok     = sw_en && (state == ST_IDLE);
    assign sw_rd     = sw_ok && op == OP_READ;
    assign sw_wr     = sw_ok && op == OP_WRITE;
    assign sw_free   = sw_ok && op == OP_FREE;
    assign sw_clr    = sw_ok && op == OP_CLEAR;
    assign viol_hit  = (state == ST_IDLE) && !miss && cpu_phi2 && viol;

    // table write mux: allocator install or software write
    assign tbl_we   = alloc_go || sw_wr;
    assign wr_page  = alloc_go ? miss_page : sw_page;
    assign wr_frame = alloc_go ? low_free  : sw_frame;
    assign wr_attr  = alloc_go ? '{dread: 1'b0, prog: 1'b0, valid: 1'b1}
                               : '{dread: sw_dread, prog: sw_prog, valid: sw_valid};
    assign pool_set = alloc_go || (sw_wr && sw_valid);

    pm_map_table #(.FW(FW), .VEC_FRAME(VEC_FRAME)) u_table (
        .clk       (clk),
        .rst       (rst),
        .lk_page   (cpu_addr[LAW-1:OFS_W]),
        .lk_attr   (lk_attr),
        .lk_frame  (lk_frame),
        .rd_page   (sw_page),
        .rd_attr   (rd_attr),
        .rd_frame  (rd_frame),
        .wr_en     (tbl_we),
        .wr_page   (wr_page),
        .wr_attr   (wr_attr),
        .wr_frame  (wr_frame),
        .inv_en    (sw_free),
        .inv_frame (sw_frame)
    );

    pm_frame_pool #(.FW(FW), .VEC_FRAME(VEC_FRAME)) u_pool (
        .clk      (clk),
        .rst      (rst),
        .set_en   (pool_set),
        .set_idx  (wr_frame),
        .clr_en   (sw_free),
        .clr_idx  (sw_frame),
        .any_free (any_free),
        .low_free (low_free)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            miss_page <= '0;
            phi2_q    <= 1'b0;
        end else begin
            phi2_q <= cpu_phi2;
            unique case (state)
                ST_IDLE: if (miss) begin
                    state     <= ST_FIND;
                    miss_page <= cpu_addr[LAW-1:OFS_W];
                end
                ST_FIND: state <= any_free ? ST_IDLE : ST_OOM;
                ST_OOM:  if (phi2_fall) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_oom  <= 1'b0;
            stat_viol <= 1'b0;
            sw_rdata  <= '0;
        end else begin
            if (sw_clr) begin
                stat_oom  <= 1'b0;
                stat_viol <= 1'b0;
            end
            if (state == ST_FIND && !any_free) stat_oom <= 1'b1;
            if (viol_hit) stat_viol <= 1'b1;
            if (sw_rd) sw_rdata <= {rd_attr, rd_frame};
        end
    end

    assign cpu_rdy   = ((state == ST_IDLE) && !miss) || (state == ST_OOM);
    assign phys_addr = {lk_frame, cpu_addr[OFS_W-1:0]};
    assign mem_we    = !cpu_rw && cpu_phi2 && (state == ST_IDLE) && !miss && !viol;
    assign mem_rd_ff = cpu_rw && (state == ST_OOM);
    assign irq       = stat_oom || stat_viol;

    // R3: allocation search lasts a single cycle
    a_r3_find_bounded: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIND) |=> (state != ST_FIND));

    // R3: after an install the same page no longer misses
    a_r3_install_hits: assert property (@(posedge clk) disable iff (rst)
        (alloc_go && cpu_addr[LAW-1:OFS_W] == miss_page) |=>
        (cpu_addr[LAW-1:OFS_W] != $past(miss_page) || !miss));

    // R7: out-of-memory release never writes and always interrupts
    a_r7_oom_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OOM) |-> (irq && cpu_rdy && !mem_we));

    // R5: a violating access leaves the flag set
    a_r5_viol_flagged: assert property (@(posedge clk) disable iff (rst)
        viol_hit |=> stat_viol);
endmodule

// File: tb/pm_demand_mapper_test.sv
module pm_demand_mapper_test;
    localparam int FW  = 3;
    localparam int VF  = 7;
    localparam int PAW = FW + 12;
    localparam int EW  = FW + 3;

    logic clk = 1'b0;
    logic rst;
    logic [15:0] cpu_addr;
    logic cpu_rw, cpu_sync, cpu_phi2;
    logic cpu_rdy, mem_we, mem_rd_ff, irq, stat_oom, stat_viol;
    logic [PAW-1:0] phys_addr;
    logic sw_en, sw_valid, sw_prog, sw_dread;
    logic [1:0] sw_op;
    logic [3:0] sw_page;
    logic [FW-1:0] sw_frame;
    logic [EW-1:0] sw_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    pm_demand_mapper #(.FW(FW), .VEC_FRAME(VF)) uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_sync(cpu_sync), .cpu_phi2(cpu_phi2), .cpu_rdy(cpu_rdy),
        .phys_addr(phys_addr), .mem_we(mem_we), .mem_rd_ff(mem_rd_ff),
        .irq(irq), .stat_oom(stat_oom), .stat_viol(stat_viol),
        .sw_en(sw_en), .sw_op(sw_op), .sw_page(sw_page), .sw_frame(sw_frame),
        .sw_valid(sw_valid), .sw_prog(sw_prog), .sw_dread(sw_dread),
        .sw_rdata(sw_rdata)
    );

    // vector: [31:16] addr, [15] rw, [14] sync, [13:12] stalls, [11:4] frame, [3] we
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        {16'hF123, 1'b1, 1'b1, 2'd0, 8'd7, 1'b0, 3'b0},  // R1 vector page hit
        {16'h0456, 1'b1, 1'b1, 2'd2, 8'd0, 1'b0, 3'b0},  // R3 fetch miss -> frame 0
        {16'h0457, 1'b0, 1'b0, 2'd0, 8'd0, 1'b1, 3'b0},  // R1 write hit
        {16'h3ABC, 1'b0, 1'b0, 2'd2, 8'd1, 1'b1, 3'b0},  // R3 data write miss -> frame 1
        {16'h2001, 1'b1, 1'b0, 2'd2, 8'd2, 1'b0, 3'b0},  // R4 lowest free -> frame 2
        {16'h3FFF, 1'b1, 1'b0, 2'd0, 8'd1, 1'b0, 3'b0}   // R1 read hit
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_access(input logic [15:0] a, input logic rw, input logic sy,
                              output int st, output logic [PAW-1:0] pa,
                              output logic we, output logic ff);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; cpu_sync = sy; cpu_phi2 = 1'b0;
        #1;
        st = 0;
        while (!cpu_rdy && st < 20) begin
            @(negedge clk); #1; st++;
        end
        @(negedge clk);
        cpu_phi2 = 1'b1;
        #1;
        pa = phys_addr; we = mem_we; ff = mem_rd_ff;
        @(negedge clk);
        cpu_phi2 = 1'b0; cpu_addr = 16'hF000; cpu_rw = 1'b1; cpu_sync = 1'b1;
        #1;
    endtask

    task automatic sw_cmd(input logic [1:0] op, input logic [3:0] pg, input logic [FW-1:0] fr,
                          input logic v, input logic p, input logic d);
        @(negedge clk);
        sw_en = 1'b1; sw_op = op; sw_page = pg; sw_frame = fr;
        sw_valid = v; sw_prog = p; sw_dread = d;
        @(negedge clk);
        sw_en = 1'b0;
        #1;
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int st;
        logic [PAW-1:0] pa;
        logic we, ff;

        rst = 1'b1; cpu_addr = 16'hF000; cpu_rw = 1'b1; cpu_sync = 1'b1; cpu_phi2 = 1'b0;
        sw_en = 1'b0; sw_op = 2'd0; sw_page = '0; sw_frame = '0;
        sw_valid = 1'b0; sw_prog = 1'b0; sw_dread = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R2 reset state
        chk("R2 irq", 32'(irq), 0);
        chk("R2 flags", {30'd0, stat_oom, stat_viol}, 0);
        sw_cmd(2'd0, 4'd0, '0, 0, 0, 0);
        chk("R2 R8 page0 invalid", 32'(sw_rdata), 0);
        sw_cmd(2'd0, 4'd15, '0, 0, 0, 0);
        chk("R2 R8 page15 preset", 32'(sw_rdata), 32'({3'b001, 3'(VF)}));

        // table walk: R1 R3 R4
        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            cpu_access(v[31:16], v[15], v[14], st, pa, we, ff);
            chk($sformatf("R3 stalls vec%0d", i), 32'(st), 32'(v[13:12]));
            chk($sformatf("R1 phys vec%0d", i), 32'(pa), 32'({v[4+FW-1:4], v[27:16]}));
            chk($sformatf("R1 we vec%0d", i), 32'(we), 32'(v[3]));
        end

        // R8 read back allocated entry: page 3 -> frame 1, valid only
        sw_cmd(2'd0, 4'd3, '0, 0, 0, 0);
        chk("R8 R4 page3 entry", 32'(sw_rdata), 32'(6'b001_001));

        // R9 write page 5: frame 4, valid, program, not data-readable
        sw_cmd(2'd1, 4'd5, 3'd4, 1, 1, 0);
        sw_cmd(2'd0, 4'd5, '0, 0, 0, 0);
        chk("R9 page5 written", 32'(sw_rdata), 32'(6'b011_100));

        // R5 write to program page
        cpu_access(16'h5010, 1'b0, 1'b0, st, pa, we, ff);
        chk("R5 no stall", 32'(st), 0);
        chk("R5 write blocked", 32'(we), 0);
        chk("R5 viol flag", 32'(stat_viol), 1);
        chk("R5 irq", 32'(irq), 1);

        // R11 clear
        sw_cmd(2'd3, '0, '0, 0, 0, 0);
        chk("R11 flags cleared", {30'd0, stat_oom, stat_viol}, 0);
        chk("R11 irq low", 32'(irq), 0);

        // R6 program page reads
        cpu_access(16'h5020, 1'b1, 1'b1, st, pa, we, ff);
        chk("R6 fetch allowed", 32'(stat_viol), 0);
        cpu_access(16'h5021, 1'b1, 1'b0, st, pa, we, ff);
        chk("R6 data read violates", 32'(stat_viol), 1);
        sw_cmd(2'd3, '0, '0, 0, 0, 0);
        sw_cmd(2'd1, 4'd5, 3'd4, 1, 1, 1);
        cpu_access(16'h5022, 1'b1, 1'b0, st, pa, we, ff);
        chk("R6 data-readable allowed", 32'(stat_viol), 0);
        chk("R6 phys frame4", 32'(pa), 32'({3'd4, 12'h022}));

        // R9 frame 4 occupied by the write: next miss skips it
        cpu_access(16'h6000, 1'b1, 1'b1, st, pa, we, ff);
        chk("R4 page6 frame3", 32'(pa[PAW-1:12]), 3);
        cpu_access(16'h7000, 1'b1, 1'b1, st, pa, we, ff);
        chk("R9 R4 page7 skips frame4", 32'(pa[PAW-1:12]), 5);

        // R10 free frame 1: page 3 invalidated, frame reclaimed
        sw_cmd(2'd2, '0, 3'd1, 0, 0, 0);
        sw_cmd(2'd0, 4'd3, '0, 0, 0, 0);
        chk("R10 page3 invalid", 32'(sw_rdata[FW]), 0);
        cpu_access(16'h3010, 1'b1, 1'b0, st, pa, we, ff);
        chk("R10 refault stalls", 32'(st), 2);
        chk("R10 frame1 reused", 32'(pa[PAW-1:12]), 1);

        // R7 fill last frame then run out
        cpu_access(16'h8000, 1'b1, 1'b1, st, pa, we, ff);
        chk("R4 page8 frame6", 32'(pa[PAW-1:12]), 6);
        cpu_access(16'h9000, 1'b1, 1'b0, st, pa, we, ff);
        chk("R7 stall then release", 32'(st), 2);
        chk("R7 read forced", 32'(ff), 1);
        chk("R7 oom flag", 32'(stat_oom), 1);
        chk("R7 irq", 32'(irq), 1);
        cpu_access(16'h9004, 1'b0, 1'b0, st, pa, we, ff);
        chk("R7 write dropped", 32'(we), 0);
        chk("R7 write no ff", 32'(ff), 0);
        sw_cmd(2'd0, 4'd9, '0, 0, 0, 0);
        chk("R7 page9 still invalid", 32'(sw_rdata[FW]), 0);
        sw_cmd(2'd3, '0, '0, 0, 0, 0);
        chk("R11 oom cleared", 32'(irq), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule